// File: doc/BRIEF.md
# Cache Array Software Access Port

This block gives privileged software a direct, load/store view of a set-associative cache's tag storage and line storage. Two fixed 16-MiB address windows are claimed on the core data bus: one reaches the tag entries, the other reaches individual 32-bit words of cached lines. Within a window, low address bits choose the set, the way and, for line storage, the word within the line. Higher bits inside the window are ignored, so every entry repeats throughout its window.

A tag write unpacks the write data into the stored tag, replacement-order (LRU) bits, dirty flag and valid flag. A tag read packs the same fields back into the same bit positions. Only privileged, 32-bit, non-fetch accesses are honoured. Any other access that lands in a window gets an error response and changes nothing. Responses arrive one cycle after the request, and requests outside both windows are left for other bus targets.

Top module: `cmap_port`

## Requirements
- R1: A request with address bits [31:24] equal to 0xF0 targets tag storage, and one with 0xF1 targets line storage. Any other address is not claimed, and `rsp_valid` stays low in the following cycle.
- R2: A claimed request sampled at a rising edge produces `rsp_valid` high for exactly the next cycle. `rsp_err` is never high while `rsp_valid` is low.
- R3: A claimed request whose `req_size` is not 2 (0 = byte, 1 = 16-bit, 2 = 32-bit) gets `rsp_err` = 1 and writes nothing.
- R4: A claimed request with `req_fetch` = 1 gets `rsp_err` = 1 and writes nothing.
- R5: A claimed request with `req_priv` = 0 gets `rsp_err` = 1 and writes nothing.
- R6: Tag word layout: bits [31:10] hold the tag, bits [9:4] the LRU bits, bit 1 the dirty flag and bit 0 the valid flag. Bits 3:2 are discarded on write and read as 0.
- R7: Address bits [10:4] select the set and bits [12:11] select the way. Bits [23:13] and [1:0] are ignored, and each entry is independent of every other entry.
- R8: In line storage, address bits [3:2] select the 32-bit word within the line. A write followed by a read of the same location returns the written word.
- R9: Reset clears every tag entry to zero and drives `rsp_valid`, `rsp_err` and `rsp_rdata` to zero.
- R10: `rsp_rdata` is zero for error responses and for successful writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| req_priv | input | 1 | Requester is in privileged mode |
| req_fetch | input | 1 | Request is an instruction fetch |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Access was refused |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 128 sets, 4 ways, 4 words per line, a 22-bit tag and 6 LRU bits. With these values the bench can reach the last set (0x7F), the last way and the last word of a line through real addresses. It also exercises the ignored in-window bits [23:13] as aliases of a written entry. Because the tag fields fill bits 31:4 exactly, the zeroed gap at bits 3:2 is observable, which lets the bench confirm that those bits are discarded on write.

// File: rtl/cmap_pkg.sv
package cmap_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_LONG = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      WIN_NONE = 2'd0,
      WIN_TAG  = 2'd1,
      WIN_LINE = 2'd2
   } win_e;

   localparam logic [7:0] TAG_WIN_HI  = 8'hF0;
   localparam logic [7:0] LINE_WIN_HI = 8'hF1;
endpackage

// File: rtl/cmap_decode.sv
module cmap_decode
   import cmap_pkg::*;
#(
   parameter int SET_BITS  = 7,
   parameter int WAY_BITS  = 2,
   parameter int WORD_BITS = 2
) (
   input  logic                 req_valid,
   input  logic [31:0]          addr,
   input  logic [1:0]           size,
   input  logic                 priv,
   input  logic                 fetch,
   output win_e                 win,
   output logic                 claimed,
   output logic                 legal,
   output logic [SET_BITS-1:0]  set_idx,
   output logic [WAY_BITS-1:0]  way_idx,
   output logic [WORD_BITS-1:0] word_idx
);
   localparam int SET_LSB = 2 + WORD_BITS;
   localparam int WAY_LSB = SET_LSB + SET_BITS;

   logic unused_addr;
   assign unused_addr = ^addr;

   always_comb begin
      if (addr[31:24] == TAG_WIN_HI)       win = WIN_TAG;
      else if (addr[31:24] == LINE_WIN_HI) win = WIN_LINE;
      else                                 win = WIN_NONE;
   end

   assign claimed  = req_valid && (win != WIN_NONE);
   assign legal    = (acc_size_e'(size) == SZ_LONG) && priv && !fetch;
   assign set_idx  = addr[SET_LSB +: SET_BITS];
   assign way_idx  = addr[WAY_LSB +: WAY_BITS];
   assign word_idx = addr[2 +: WORD_BITS];
endmodule

// File: rtl/cmap_tag_store.sv
module cmap_tag_store #(
   parameter int SET_BITS = 7,
   parameter int WAY_BITS = 2,
   parameter int ENT_W    = 30
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [SET_BITS-1:0] set_idx,
   input  logic [WAY_BITS-1:0] way_idx,
   input  logic [ENT_W-1:0]    wr_ent,
   output logic [ENT_W-1:0]    rd_ent
);
   localparam int SETS = 1 << SET_BITS;
   localparam int WAYS = 1 << WAY_BITS;

   logic [ENT_W-1:0] way_rd [WAYS];

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [ENT_W-1:0] mem [SETS];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int s = 0; s < SETS; s++) mem[s] <= '0;
         end else if (we && (way_idx == WAY_BITS'(w))) begin
            mem[set_idx] <= wr_ent;
         end
      end
      assign way_rd[w] = mem[set_idx];
   end

   assign rd_ent = way_rd[way_idx];
endmodule

// File: rtl/cmap_line_store.sv
module cmap_line_store #(
   parameter int SET_BITS  = 7,
   parameter int WAY_BITS  = 2,
   parameter int WORD_BITS = 2
) (
   input  logic                 clk,
   input  logic                 we,
   input  logic [SET_BITS-1:0]  set_idx,
   input  logic [WAY_BITS-1:0]  way_idx,
   input  logic [WORD_BITS-1:0] word_idx,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata
);
   localparam int WAYS  = 1 << WAY_BITS;
   localparam int DEPTH = 1 << (SET_BITS + WORD_BITS);

   logic [31:0] way_rd [WAYS];
   logic [SET_BITS+WORD_BITS-1:0] slot;
   assign slot = {set_idx, word_idx};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [31:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (way_idx == WAY_BITS'(w))) mem[slot] <= wdata;
      end
      assign way_rd[w] = mem[slot];
   end

   assign rdata = way_rd[way_idx];
endmodule

// File: rtl/cmap_port.sv
module cmap_port
   import cmap_pkg::*;
#(
   parameter int SET_BITS  = 7,
   parameter int WAY_BITS  = 2,
   parameter int WORD_BITS = 2,
   parameter int TAG_BITS  = 22,
   parameter int LRU_BITS  = 6,
   parameter int LRU_LSB   = 4
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic [31:0] req_addr,
   input  logic [31:0] req_wdata,
   input  logic        req_write,
   input  logic [1:0]  req_size,
   input  logic        req_priv,
   input  logic        req_fetch,
   output logic        rsp_valid,
   output logic        rsp_err,
   output logic [31:0] rsp_rdata
);
   localparam int ENT_W   = TAG_BITS + LRU_BITS + 2;
   localparam int IDX_TOP = 2 + WORD_BITS + SET_BITS + WAY_BITS;

   if (TAG_BITS < 1 || LRU_BITS < 1) begin : g_bad_fields
      $error("tag and LRU fields need at least one bit");
   end
   if (LRU_LSB < 2 || LRU_LSB + LRU_BITS + TAG_BITS > 32) begin : g_bad_layout
      $error("tag word fields overlap or exceed 32 bits");
   end
   if (IDX_TOP > 24) begin : g_bad_index
      $error("entry index does not fit inside a 16 MiB window");
   end

   win_e                 win;
   logic                 claimed, legal;
   logic [SET_BITS-1:0]  set_idx;
   logic [WAY_BITS-1:0]  way_idx;
   logic [WORD_BITS-1:0] word_idx;

   cmap_decode #(
      .SET_BITS (SET_BITS),
      .WAY_BITS (WAY_BITS),
      .WORD_BITS(WORD_BITS)
   ) u_dec (
      .req_valid(req_valid),
      .addr     (req_addr),
      .size     (req_size),
      .priv     (req_priv),
      .fetch    (req_fetch),
      .win      (win),
      .claimed  (claimed),
      .legal    (legal),
      .set_idx  (set_idx),
      .way_idx  (way_idx),
      .word_idx (word_idx)
   );

   logic do_ok, tag_we, line_we;
   assign do_ok   = claimed && legal;
   assign tag_we  = do_ok && req_write && (win == WIN_TAG);
   assign line_we = do_ok && req_write && (win == WIN_LINE);

   logic [ENT_W-1:0] wr_ent, rd_ent;
   assign wr_ent = {req_wdata[31 -: TAG_BITS],
                    req_wdata[LRU_LSB +: LRU_BITS],
                    req_wdata[1],
                    req_wdata[0]};

   cmap_tag_store #(
      .SET_BITS(SET_BITS),
      .WAY_BITS(WAY_BITS),
      .ENT_W   (ENT_W)
   ) u_tags (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (tag_we),
      .set_idx(set_idx),
      .way_idx(way_idx),
      .wr_ent (wr_ent),
      .rd_ent (rd_ent)
   );

   logic [31:0] line_rd;

   cmap_line_store #(
      .SET_BITS (SET_BITS),
      .WAY_BITS (WAY_BITS),
      .WORD_BITS(WORD_BITS)
   ) u_lines (
      .clk     (clk),
      .we      (line_we),
      .set_idx (set_idx),
      .way_idx (way_idx),
      .word_idx(word_idx),
      .wdata   (req_wdata),
      .rdata   (line_rd)
   );

   logic [31:0] tag_word;
   always_comb begin
      tag_word                      = '0;
      tag_word[31 -: TAG_BITS]      = rd_ent[ENT_W-1 -: TAG_BITS];
      tag_word[LRU_LSB +: LRU_BITS] = rd_ent[2 +: LRU_BITS];
      tag_word[1:0]                 = rd_ent[1:0];
   end

   logic [31:0] rd_next;
   always_comb begin
      rd_next = '0;
      if (do_ok && !req_write) rd_next = (win == WIN_TAG) ? tag_word : line_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= claimed;
         rsp_err   <= claimed && !legal;
         rsp_rdata <= rd_next;
      end
   end
endmodule

// File: rtl/cmap_port_chk.sv
module cmap_port_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [31:0] req_addr,
   input logic        req_write,
   input logic [1:0]  req_size,
   input logic        req_priv,
   input logic        req_fetch,
   input logic        rsp_valid,
   input logic        rsp_err,
   input logic [31:0] rsp_rdata
);
   logic in_win;
   assign in_win = req_valid && (req_addr[31:25] == 7'b1111000);

   p_unclaimed_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_win |=> !rsp_valid);

   p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |=> rsp_valid);

   p_err_in_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> rsp_valid);

   p_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && req_size != 2'd2) |=> rsp_err);

   p_fetch_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && req_fetch) |=> rsp_err);

   p_user_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !req_priv) |=> rsp_err);

   p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == 32'd0));

   p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && req_write) |=> (rsp_rdata == 32'd0));

   p_legal_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && req_size == 2'd2 && req_priv && !req_fetch) |=> !rsp_err);
endmodule

bind cmap_port cmap_port_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_addr (req_addr),
   .req_write(req_write),
   .req_size (req_size),
   .req_priv (req_priv),
   .req_fetch(req_fetch),
   .rsp_valid(rsp_valid),
   .rsp_err  (rsp_err),
   .rsp_rdata(rsp_rdata)
);

// File: tb/cmap_port_tb.sv
module cmap_port_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic        req_priv = 1'b1;
   logic        req_fetch = 1'b0;
   logic        rsp_valid, rsp_err;
   logic [31:0] rsp_rdata;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cmap_port u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_write(req_write), .req_size(req_size),
      .req_priv(req_priv), .req_fetch(req_fetch), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
   );

   typedef struct packed {
      logic [3:0]  rq;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic        wr;
      logic [1:0]  sz;
      logic        priv;
      logic        fetch;
      logic        ev;
      logic        ee;
      logic [31:0] ed;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [NV] = '{
      '{4'd9,  32'hF0000850, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R9 cleared tag
      '{4'd10, 32'hF0000850, 32'hABCDE2AF, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R10 write rdata 0
      '{4'd6,  32'hF0000850, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'hABCDE2A3}, // R6 packing
      '{4'd7,  32'hF0001050, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R7 other way
      '{4'd7,  32'hF0000860, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R7 other set
      '{4'd8,  32'hF1001FF8, 32'h12345678, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R8 word 2
      '{4'd8,  32'hF1001FFC, 32'h9ABCDEF0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0},        // R8 word 3
      '{4'd8,  32'hF1001FF8, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h12345678}, // R8
      '{4'd8,  32'hF1001FFC, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h9ABCDEF0}, // R8
      '{4'd3,  32'hF1001FF8, 32'hFFFFFFFF, 1'b1, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0},        // R3 byte
      '{4'd5,  32'hF1001FF8, 32'hFFFFFFFF, 1'b1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0},        // R5 user
      '{4'd4,  32'hF1001FF8, 32'h0,        1'b0, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0},        // R4 fetch
      '{4'd4,  32'hF1001FF8, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'h12345678}, // R4 R5 R3 unchanged
      '{4'd3,  32'hF0000850, 32'h0,        1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0},        // R3 16-bit tag
      '{4'd3,  32'hF0000850, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'hABCDE2A3}, // R3 unchanged
      '{4'd1,  32'hF2000850, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},        // R1 above
      '{4'd1,  32'hEF000850, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0},        // R1 below
      '{4'd7,  32'hF0ABC853, 32'h0,        1'b0, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 32'hABCDE2A3}  // R7 alias bits
   };

   task automatic chk(input string tag, input logic v, input logic e, input logic [31:0] d,
                      input logic xv, input logic xe, input logic [31:0] xd);
      checks++;
      if (v !== xv || e !== xe || d !== xd) begin
         fails++;
         $display("FAIL %s: got valid=%b err=%b rdata=%h, expected valid=%b err=%b rdata=%h",
                  tag, v, e, d, xv, xe, xd);
      end
   endtask

   task automatic issue(input logic [31:0] a, input logic [31:0] wd, input logic wr,
                        input logic [1:0] sz, input logic pv, input logic ft);
      req_valid = 1'b1; req_addr = a; req_wdata = wd; req_write = wr;
      req_size = sz; req_priv = pv; req_fetch = ft;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_size = 2'd2; req_priv = 1'b1; req_fetch = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      fails++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset outputs", rsp_valid, rsp_err, rsp_rdata, 1'b0, 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].addr, VECS[i].wdata, VECS[i].wr, VECS[i].sz, VECS[i].priv, VECS[i].fetch);
         chk($sformatf("R%0d vector %0d", VECS[i].rq, i), rsp_valid, rsp_err, rsp_rdata,
             VECS[i].ev, VECS[i].ee, VECS[i].ed);
      end

      // R2: response lasts one cycle when no new request follows
      @(negedge clk);
      chk("R2 single-cycle response", rsp_valid, rsp_err, rsp_rdata, 1'b0, 1'b0, 32'h0);

      // R7: last set, last way, tag independent of set 5 way 1
      issue(32'hF0001FF0, 32'h00000401, 1'b1, 2'd2, 1'b1, 1'b0);
      issue(32'hF0001FF0, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0);
      chk("R7 last entry", rsp_valid, rsp_err, rsp_rdata, 1'b1, 1'b0, 32'h00000401);
      issue(32'hF0000850, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0);
      chk("R7 neighbour kept", rsp_valid, rsp_err, rsp_rdata, 1'b1, 1'b0, 32'hABCDE2A3);

      // R9: reset in mid-run clears tag entries
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 outputs in reset", rsp_valid, rsp_err, rsp_rdata, 1'b0, 1'b0, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      issue(32'hF0000850, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0);
      chk("R9 tag cleared", rsp_valid, rsp_err, rsp_rdata, 1'b1, 1'b0, 32'h0);
      issue(32'hF0001FF0, 32'h0, 1'b0, 2'd2, 1'b1, 1'b0);
      chk("R9 last tag cleared", rsp_valid, rsp_err, rsp_rdata, 1'b1, 1'b0, 32'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule